// File: doc/BRIEF.md
# Aliased Graphics Memory Port

This block is the processor-side access port of a 4K-word graphics memory window. The lower half of the window is a read-only character table. The upper half maps a small 8-bit RAM that repeats at many alias addresses. Writes aimed at the table half are thrown away. Writes to the RAM half keep only the low data byte and land at a folded index. Reads take a single register stage and return a zero-extended byte from whichever half the address selects.

The main bus port honours a bus-isolation input. While isolation is asserted, a bus write is dropped, and a bus read returns the low address bits instead of memory contents. A second debug port has the same read and write behaviour but ignores isolation. It wins over the bus port when both write in the same cycle.

Any accepted write that changes a stored byte raises a sticky change flag. Downstream logic can use this flag to learn that graphics data must be refetched. It clears the flag with a one-cycle pulse.

Top module: `gfx_mem_port`

## Requirements
- R1: After reset, every RAM byte reads as zero, `gfx_dirty` is 0 and both read-valid outputs are 0.
- R2: A read strobe whose address has window bit WIN_AW-1 (bit 11 by default) clear returns the table byte at address bits WIN_AW-2:0, zero-extended, on the data output one cycle later with the valid output high. Address bits at WIN_AW and above have no effect.
- R3: A read strobe whose address has bit WIN_AW-1 set returns the RAM byte at address bits RAM_AW-1:0 (bits 8:0 by default), zero-extended, one cycle later. Every alias in the upper half reaches the same byte.
- R4: A write on either port whose address has bit WIN_AW-1 clear changes no RAM byte and no table byte.
- R5: An accepted write to the RAM half stores bits 7:0 of the write data at index address bits RAM_AW-1:0. Higher data bits are discarded.
- R6: While `bus_iso` is 1, a bus write is dropped. A bus read returns address bits ISO_W-1:0 (13:0 by default), zero-extended, one cycle later.
- R7: The debug port reads and writes memory normally whatever the value of `bus_iso`.
- R8: When both write strobes are high in one cycle, only the debug write can take effect and the bus write is dropped. This holds even if the debug write targets the table half.
- R9: An accepted write whose byte differs from the stored byte sets `gfx_dirty` at the next edge. A write of an equal byte leaves it unchanged.
- R10: `gfx_dirty` stays 1 until `dirty_clr` is pulsed. If a change and a clear occur in the same cycle, the flag ends up 1.
- R11: A read and a write to the same RAM index in the same cycle return the byte held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_iso | input | 1 | Bus isolation window active |
| bus_re | input | 1 | Bus read strobe |
| bus_we | input | 1 | Bus write strobe |
| bus_addr | input | ADDR_W | Bus address (window offset in low bits) |
| bus_wdata | input | DATA_W | Bus write data |
| bus_rdata | output | DATA_W | Bus read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Bus read data valid |
| dbg_re | input | 1 | Debug read strobe |
| dbg_we | input | 1 | Debug write strobe |
| dbg_addr | input | ADDR_W | Debug address |
| dbg_wdata | input | DATA_W | Debug write data |
| dbg_rdata | output | DATA_W | Debug read data, valid with dbg_rvalid |
| dbg_rvalid | output | 1 | Debug read data valid |
| dirty_clr | input | 1 | One-cycle clear of the change flag |
| gfx_dirty | output | 1 | Sticky flag: a stored byte changed |

## Verification
The bench builds the block with WIN_AW=8 and RAM_AW=4, which gives a 128-byte table and a 16-byte RAM aliased eight times over the upper half. With these values every window offset can be written and every alias read back in a few thousand cycles. A folding or filtering error therefore shows up as a wrong byte somewhere in the full sweep. ISO_W stays at 14, so the isolation echo is checked against addresses with nonzero high bits.

// File: rtl/gmp_pkg.sv
package gmp_pkg;
  typedef enum logic {SRC_BUS = 1'b0, SRC_DBG = 1'b1} gmp_src_e;
  localparam int GMP_BYTE_W = 8;
endpackage

// File: rtl/gmp_rom.sv
module gmp_rom #(
  parameter int ROM_AW   = 11,
  parameter int BYTE_W   = 8,
  parameter int ROM_SEED = 90
) (
  input  logic [ROM_AW-1:0] raddr_a,
  input  logic [ROM_AW-1:0] raddr_b,
  output logic [BYTE_W-1:0] rbyte_a,
  output logic [BYTE_W-1:0] rbyte_b
);
  localparam int DEPTH = 1 << ROM_AW;

  logic [BYTE_W-1:0] tbl [DEPTH];

  function automatic logic [BYTE_W-1:0] fill_byte(input int unsigned i);
    int unsigned t;
    t = i * 37 + ROM_SEED + (i >> 8);
    return t[BYTE_W-1:0];
  endfunction

  initial begin
    for (int i = 0; i < DEPTH; i++) tbl[i] = fill_byte(i);
  end

  assign rbyte_a = tbl[raddr_a];
  assign rbyte_b = tbl[raddr_b];
endmodule

// File: rtl/gmp_ram.sv
module gmp_ram #(
  parameter int RAM_AW = 9,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [RAM_AW-1:0] widx,
  input  logic [BYTE_W-1:0] wbyte,
  output logic [BYTE_W-1:0] old_byte,
  input  logic [RAM_AW-1:0] ridx_a,
  input  logic [RAM_AW-1:0] ridx_b,
  output logic [BYTE_W-1:0] rbyte_a,
  output logic [BYTE_W-1:0] rbyte_b
);
  localparam int DEPTH = 1 << RAM_AW;

  logic [BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[widx] <= wbyte;
    end
  end

  assign old_byte = mem[widx];
  assign rbyte_a  = mem[ridx_a];
  assign rbyte_b  = mem[ridx_b];
endmodule

// File: rtl/gmp_wr_arb.sv
module gmp_wr_arb
  import gmp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int WIN_AW = 12,
  parameter int RAM_AW = 9,
  parameter int BYTE_W = 8
) (
  input  logic              bus_we,
  input  logic              bus_iso,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              dbg_we,
  input  logic [ADDR_W-1:0] dbg_addr,
  input  logic [DATA_W-1:0] dbg_wdata,
  output logic              wr_fire,
  output gmp_src_e          wr_src,
  output logic [RAM_AW-1:0] wr_idx,
  output logic [BYTE_W-1:0] wr_byte
);
  function automatic logic in_ram_half(input logic [ADDR_W-1:0] a);
    return a[WIN_AW-1];
  endfunction

  function automatic logic [RAM_AW-1:0] fold_idx(input logic [ADDR_W-1:0] a);
    return a[RAM_AW-1:0];
  endfunction

  logic dbg_ok, bus_ok;
  logic unused_hi;

  assign dbg_ok = dbg_we && in_ram_half(dbg_addr);
  assign bus_ok = bus_we && !bus_iso && !dbg_we && in_ram_half(bus_addr);

  always_comb begin
    wr_fire = dbg_ok || bus_ok;
    if (dbg_we) begin
      wr_src  = SRC_DBG;
      wr_idx  = fold_idx(dbg_addr);
      wr_byte = dbg_wdata[BYTE_W-1:0];
    end else begin
      wr_src  = SRC_BUS;
      wr_idx  = fold_idx(bus_addr);
      wr_byte = bus_wdata[BYTE_W-1:0];
    end
  end

  assign unused_hi = ^{bus_addr, dbg_addr, bus_wdata, dbg_wdata};
endmodule

// File: rtl/gmp_rd_resp.sv
module gmp_rd_resp #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int WIN_AW = 12,
  parameter int RAM_AW = 9,
  parameter int ISO_W  = 14,
  parameter int BYTE_W = 8,
  localparam int ROM_AW = WIN_AW - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              re,
  input  logic              iso,
  input  logic [ADDR_W-1:0] addr,
  output logic [ROM_AW-1:0] rom_idx,
  output logic [RAM_AW-1:0] ram_idx,
  input  logic [BYTE_W-1:0] rom_byte,
  input  logic [BYTE_W-1:0] ram_byte,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  function automatic logic hits_ram(input logic [ADDR_W-1:0] a);
    return a[WIN_AW-1];
  endfunction

  function automatic logic [DATA_W-1:0] iso_echo(input logic [ADDR_W-1:0] a);
    return DATA_W'(a[ISO_W-1:0]);
  endfunction

  logic [DATA_W-1:0] next_data;
  logic unused_addr;

  assign rom_idx = addr[ROM_AW-1:0];
  assign ram_idx = addr[RAM_AW-1:0];

  always_comb begin
    if (iso)                 next_data = iso_echo(addr);
    else if (hits_ram(addr)) next_data = DATA_W'(ram_byte);
    else                     next_data = DATA_W'(rom_byte);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= re;
      if (re) rdata <= next_data;
    end
  end

  assign unused_addr = ^addr;
endmodule

// File: rtl/gfx_mem_port.sv
module gfx_mem_port
  import gmp_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int WIN_AW   = 12,
  parameter int RAM_AW   = 9,
  parameter int ISO_W    = 14,
  parameter int ROM_SEED = 90,
  localparam int BYTE_W  = GMP_BYTE_W,
  localparam int ROM_AW  = WIN_AW - 1,
  localparam int NPORT   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_iso,
  input  logic              bus_re,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic              dbg_re,
  input  logic              dbg_we,
  input  logic [ADDR_W-1:0] dbg_addr,
  input  logic [DATA_W-1:0] dbg_wdata,
  output logic [DATA_W-1:0] dbg_rdata,
  output logic              dbg_rvalid,
  input  logic              dirty_clr,
  output logic              gfx_dirty
);
  // named internal events, observed by the bound checker
  logic              wr_fire;
  gmp_src_e          wr_src;
  logic              wr_from_dbg;
  logic [RAM_AW-1:0] wr_idx;
  logic [BYTE_W-1:0] wr_byte;
  logic [BYTE_W-1:0] old_byte;
  logic              byte_chg;

  logic [NPORT-1:0]  re_v, iso_v, rvalid_v;
  logic [ADDR_W-1:0] addr_v     [NPORT];
  logic [DATA_W-1:0] rdata_v    [NPORT];
  logic [ROM_AW-1:0] rom_idx_v  [NPORT];
  logic [RAM_AW-1:0] ram_idx_v  [NPORT];
  logic [BYTE_W-1:0] rom_byte_v [NPORT];
  logic [BYTE_W-1:0] ram_byte_v [NPORT];

  gmp_wr_arb #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_AW(WIN_AW),
               .RAM_AW(RAM_AW), .BYTE_W(BYTE_W)) u_arb (
    .bus_we(bus_we), .bus_iso(bus_iso), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .dbg_we(dbg_we), .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata),
    .wr_fire(wr_fire), .wr_src(wr_src), .wr_idx(wr_idx), .wr_byte(wr_byte)
  );

  assign wr_from_dbg = (wr_src == SRC_DBG);

  gmp_ram #(.RAM_AW(RAM_AW), .BYTE_W(BYTE_W)) u_ram (
    .clk(clk), .rst_n(rst_n), .we(wr_fire), .widx(wr_idx), .wbyte(wr_byte),
    .old_byte(old_byte),
    .ridx_a(ram_idx_v[0]), .ridx_b(ram_idx_v[1]),
    .rbyte_a(ram_byte_v[0]), .rbyte_b(ram_byte_v[1])
  );

  gmp_rom #(.ROM_AW(ROM_AW), .BYTE_W(BYTE_W), .ROM_SEED(ROM_SEED)) u_rom (
    .raddr_a(rom_idx_v[0]), .raddr_b(rom_idx_v[1]),
    .rbyte_a(rom_byte_v[0]), .rbyte_b(rom_byte_v[1])
  );

  // port 0 is the bus side, port 1 the debug side (never isolated)
  assign re_v      = {dbg_re, bus_re};
  assign iso_v     = {1'b0, bus_iso};
  assign addr_v[0] = bus_addr;
  assign addr_v[1] = dbg_addr;

  for (genvar p = 0; p < NPORT; p++) begin : g_rd
    gmp_rd_resp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_AW(WIN_AW),
                  .RAM_AW(RAM_AW), .ISO_W(ISO_W), .BYTE_W(BYTE_W)) u_rd (
      .clk(clk), .rst_n(rst_n), .re(re_v[p]), .iso(iso_v[p]), .addr(addr_v[p]),
      .rom_idx(rom_idx_v[p]), .ram_idx(ram_idx_v[p]),
      .rom_byte(rom_byte_v[p]), .ram_byte(ram_byte_v[p]),
      .rdata(rdata_v[p]), .rvalid(rvalid_v[p])
    );
  end

  assign bus_rdata  = rdata_v[0];
  assign bus_rvalid = rvalid_v[0];
  assign dbg_rdata  = rdata_v[1];
  assign dbg_rvalid = rvalid_v[1];

  assign byte_chg = wr_fire && (old_byte != wr_byte);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         gfx_dirty <= 1'b0;
    else if (byte_chg)  gfx_dirty <= 1'b1;
    else if (dirty_clr) gfx_dirty <= 1'b0;
  end
endmodule

// File: rtl/gfx_mem_port_chk.sv
module gfx_mem_port_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int WIN_AW = 12,
  parameter int ISO_W  = 14,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_iso,
  input logic              bus_re,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_rvalid,
  input logic              dbg_re,
  input logic              dbg_we,
  input logic [ADDR_W-1:0] dbg_addr,
  input logic              dbg_rvalid,
  input logic              dirty_clr,
  input logic              gfx_dirty,
  input logic              wr_fire,
  input logic              wr_from_dbg,
  input logic [BYTE_W-1:0] old_byte,
  input logic [BYTE_W-1:0] wr_byte
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!gfx_dirty && !bus_rvalid && !dbg_rvalid));

  assert_bus_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re |=> bus_rvalid);

  assert_bus_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> !bus_rvalid);

  assert_dbg_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_re |=> dbg_rvalid);

  assert_bus_rom_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !dbg_we && !bus_addr[WIN_AW-1]) |-> !wr_fire);

  assert_dbg_rom_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_we && !dbg_addr[WIN_AW-1]) |-> !wr_fire);

  assert_iso_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_iso && !dbg_we) |-> !wr_fire);

  assert_iso_echo_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_iso) |=> (bus_rdata == DATA_W'($past(bus_addr[ISO_W-1:0]))));

  assert_dbg_ignores_iso_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_we && dbg_addr[WIN_AW-1]) |-> wr_fire);

  assert_dbg_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_we && bus_we && wr_fire) |-> wr_from_dbg);

  assert_dirty_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && (old_byte != wr_byte)) |=> gfx_dirty);

  assert_dirty_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!gfx_dirty && !(wr_fire && (old_byte != wr_byte))) |=> !gfx_dirty);

  assert_dirty_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (gfx_dirty && !dirty_clr) |=> gfx_dirty);
endmodule

bind gfx_mem_port gfx_mem_port_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_AW(WIN_AW), .ISO_W(ISO_W), .BYTE_W(BYTE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_iso(bus_iso), .bus_re(bus_re), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
  .dbg_re(dbg_re), .dbg_we(dbg_we), .dbg_addr(dbg_addr), .dbg_rvalid(dbg_rvalid),
  .dirty_clr(dirty_clr), .gfx_dirty(gfx_dirty), .wr_fire(wr_fire),
  .wr_from_dbg(wr_from_dbg), .old_byte(old_byte), .wr_byte(wr_byte)
);

// File: tb/gfx_mem_port_bench.sv
module gfx_mem_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;
  localparam int WIN_AW = 8;
  localparam int RAM_AW = 4;
  localparam int ISO_W  = 14;
  localparam int SEED   = 90;
  localparam int ROM_N  = 1 << (WIN_AW - 1);
  localparam int RAM_N  = 1 << RAM_AW;
  localparam int HALF   = 1 << (WIN_AW - 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_iso = 1'b0, bus_re = 1'b0, bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0, dbg_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0, dbg_wdata = '0;
  logic [DATA_W-1:0] bus_rdata, dbg_rdata;
  logic bus_rvalid, dbg_rvalid;
  logic dbg_re = 1'b0, dbg_we = 1'b0, dirty_clr = 1'b0;
  logic gfx_dirty;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] ram_m [RAM_N];

  always #(CLK_PERIOD/2) clk = ~clk;

  gfx_mem_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_AW(WIN_AW), .RAM_AW(RAM_AW),
                 .ISO_W(ISO_W), .ROM_SEED(SEED)) u_gfx_mem_port (
    .clk(clk), .rst_n(rst_n), .bus_iso(bus_iso), .bus_re(bus_re), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .dbg_re(dbg_re), .dbg_we(dbg_we), .dbg_addr(dbg_addr),
    .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata), .dbg_rvalid(dbg_rvalid),
    .dirty_clr(dirty_clr), .gfx_dirty(gfx_dirty)
  );

  function automatic logic [15:0] rom_exp(input int i);
    return 16'((i * 37 + SEED + i / 256) % 256);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input bit dbg, input logic [15:0] a,
                    output logic [15:0] d, output logic v);
    @(negedge clk);
    if (dbg) begin dbg_re = 1'b1; dbg_addr = a; end
    else     begin bus_re = 1'b1; bus_addr = a; end
    @(negedge clk);
    dbg_re = 1'b0; bus_re = 1'b0;
    d = dbg ? dbg_rdata : bus_rdata;
    v = dbg ? dbg_rvalid : bus_rvalid;
  endtask

  task automatic wr(input bit dbg, input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    if (dbg) begin dbg_we = 1'b1; dbg_addr = a; dbg_wdata = d; end
    else     begin bus_we = 1'b1; bus_addr = a; bus_wdata = d; end
    @(negedge clk);
    dbg_we = 1'b0; bus_we = 1'b0;
  endtask

  task automatic clr_pulse();
    @(negedge clk); dirty_clr = 1'b1;
    @(negedge clk); dirty_clr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic v;
    for (int i = 0; i < RAM_N; i++) ram_m[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk("R1 dirty", 32'(gfx_dirty), 32'd0);
    chk("R1 rvalid", 32'({bus_rvalid, dbg_rvalid}), 32'd0);
    for (int i = 0; i < RAM_N; i++) begin
      rd(1'b1, 16'(HALF + i), d, v);
      chk("R1 ram zero", 32'(d), 32'd0);
    end

    // R2: full table sweep, junk in bits above the window
    for (int i = 0; i < ROM_N; i++) begin
      rd(1'b0, 16'(((i * 7) % 256) << 8) | 16'(i), d, v);
      chk("R2 rom data", 32'(d), 32'(rom_exp(i)));
      chk("R2 rvalid", 32'(v), 32'd1);
    end

    // R4/R5: write every window offset on the bus port
    for (int w = 0; w < 2 * HALF; w++) begin
      logic [15:0] wd;
      wd = 16'hC300 ^ 16'(w * 13);
      wr(1'b0, 16'(w) | 16'h0A00, wd);
      if (w >= HALF) ram_m[w % RAM_N] = wd[7:0];
    end
    // R3: every alias of the RAM half, with high bits set
    for (int a = HALF; a < 2 * HALF; a++) begin
      rd(1'b0, 16'(a) | 16'h5300, d, v);
      chk("R3 alias read", 32'(d), 32'(ram_m[a % RAM_N]));
    end
    for (int i = 0; i < ROM_N; i += 9) begin
      rd(1'b1, 16'(i), d, v);
      chk("R4 rom unchanged", 32'(d), 32'(rom_exp(i)));
    end

    // R5: data truncation
    wr(1'b0, 16'(HALF + 5), 16'hABCD); ram_m[5] = 8'hCD;
    rd(1'b0, 16'(HALF + 5), d, v);
    chk("R5 truncate", 32'(d), 32'h00CD);

    // R11: read and write the same index in one cycle
    @(negedge clk);
    bus_we = 1'b1; bus_re = 1'b1; bus_addr = 16'(HALF + 6); bus_wdata = 16'h0077;
    @(negedge clk);
    bus_we = 1'b0; bus_re = 1'b0;
    chk("R11 old byte", 32'(bus_rdata), 32'(ram_m[6]));
    ram_m[6] = 8'h77;
    rd(1'b0, 16'(HALF + 6), d, v);
    chk("R11 new byte", 32'(d), 32'h0077);

    // R6: isolation
    bus_iso = 1'b1;
    wr(1'b0, 16'(HALF + 7), 16'h00E1);
    foreach (d[i]) ;
    for (int k = 0; k < 8; k++) begin
      logic [15:0] a;
      a = 16'hF5A7 ^ 16'(k * 16'h1357);
      rd(1'b0, a, d, v);
      chk("R6 iso echo", 32'(d), 32'(a & 16'h3FFF));
      chk("R6 iso rvalid", 32'(v), 32'd1);
    end
    // R7: debug port ignores isolation
    rd(1'b1, 16'(HALF + 7), d, v);
    chk("R6 iso write dropped", 32'(d), 32'(ram_m[7]));
    wr(1'b1, 16'(HALF + 8), 16'h1142); ram_m[8] = 8'h42;
    rd(1'b1, 16'(HALF + 8), d, v);
    chk("R7 dbg write under iso", 32'(d), 32'h0042);
    rd(1'b1, 16'd3, d, v);
    chk("R7 dbg rom read under iso", 32'(d), 32'(rom_exp(3)));
    wr(1'b1, 16'h0010, 16'h00EE);
    bus_iso = 1'b0;
    rd(1'b0, 16'h0010, d, v);
    chk("R4 dbg rom write refused", 32'(d), 32'(rom_exp(16)));
    rd(1'b0, 16'(HALF), d, v);
    chk("R4 dbg rom write no ram", 32'(d), 32'(ram_m[0]));

    // R8: both ports write in one cycle
    @(negedge clk);
    dbg_we = 1'b1; dbg_addr = 16'(HALF + 9);  dbg_wdata = 16'h0019;
    bus_we = 1'b1; bus_addr = 16'(HALF + 10); bus_wdata = 16'h001A;
    @(negedge clk);
    dbg_we = 1'b0; bus_we = 1'b0; ram_m[9] = 8'h19;
    rd(1'b0, 16'(HALF + 9), d, v);
    chk("R8 dbg landed", 32'(d), 32'h0019);
    rd(1'b0, 16'(HALF + 10), d, v);
    chk("R8 bus dropped", 32'(d), 32'(ram_m[10]));
    @(negedge clk);
    dbg_we = 1'b1; dbg_addr = 16'd2;          dbg_wdata = 16'h0055;
    bus_we = 1'b1; bus_addr = 16'(HALF + 11); bus_wdata = 16'h005B;
    @(negedge clk);
    dbg_we = 1'b0; bus_we = 1'b0;
    rd(1'b0, 16'(HALF + 11), d, v);
    chk("R8 bus dropped vs dbg rom", 32'(d), 32'(ram_m[11]));

    // R9/R10: change flag
    clr_pulse();
    chk("R10 cleared", 32'(gfx_dirty), 32'd0);
    wr(1'b0, 16'(HALF + 12), 16'(ram_m[12]) | 16'hFF00);
    chk("R9 same byte no set", 32'(gfx_dirty), 32'd0);
    wr(1'b0, 16'(HALF + 12), 16'(ram_m[12] ^ 8'h01)); ram_m[12] ^= 8'h01;
    chk("R9 change sets", 32'(gfx_dirty), 32'd1);
    repeat (3) @(negedge clk);
    chk("R10 sticky", 32'(gfx_dirty), 32'd1);
    clr_pulse();
    chk("R10 clear", 32'(gfx_dirty), 32'd0);
    @(negedge clk);
    dirty_clr = 1'b1; bus_we = 1'b1; bus_addr = 16'(HALF + 13);
    bus_wdata = 16'(ram_m[13] ^ 8'h80);
    @(negedge clk);
    dirty_clr = 1'b0; bus_we = 1'b0; ram_m[13] ^= 8'h80;
    chk("R10 set beats clear", 32'(gfx_dirty), 32'd1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule